// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Ready and Empty Flags

This block turns bytes written by a host into asynchronous serial characters on a single line. Written bytes enter a small first-in first-out queue. A shift engine takes them one at a time and sends each as a framed character. The host chooses the character length, the parity mode and the number of stop bits. Every bit lasts sixteen pulses of an external baud tick. The line rests at logic 1 (mark) whenever nothing is being sent.

A command strobe with a 3-bit selector controls the block. The commands turn the transmitter on and off, return it to idle, and start or end a break. During a break the line is held low. Two status outputs tell the host what it may do next. The ready flag means the queue holds no waiting byte. The empty flag means the last character has fully left the line and nothing else is pending. A byte written while the transmitter is off is lost, and it is never sent later.

Top module: `uart_tx_core`

## Requirements
- R1: After the asynchronous reset, txd_o is 1, tx_rdy_o is 0, tx_emt_o is 0 and the transmitter is disabled.
- R2: A character is a 0 start bit, then 5+len_sel_i data bits sent LSB first, then an optional parity bit, then one stop bit of 1 (two when two_stop_i is 1). Each bit lasts 16 tick_i pulses. The start bit appears on the clock after the byte is taken from the queue. The configuration is sampled at that moment.
- R3: Parity modes on par_mode_i: 0 sends no parity bit, 1 gives even parity over the data bits, 2 gives odd parity, and 3 always sends a parity bit of 1.
- R4: The queue holds DEPTH bytes and sends them in write order. A write that arrives while the queue is full is dropped.
- R5: tx_rdy_o is 1 exactly when the transmitter is enabled and the queue is empty. It drops on an accepted write. It rises when the last queued byte moves to the shift engine, and also when an enable command reaches an empty queue.
- R6: tx_emt_o rises on the clock after the last stop bit completes, provided the queue is empty. It clears on an accepted write, on a disable command and on a reset-transmitter command. A character that is abandoned never sets it.
- R7: A write while the transmitter is disabled is discarded. Enabling the transmitter later does not send it.
- R8: Begin-break (code 4) while enabled drives txd_o low from the next clock. It abandons any character in progress, and queued bytes stay queued. End-break (code 5) returns txd_o to mark on the next clock, and queued bytes then resume.
- R9: Reset-transmitter (code 3) empties the queue, abandons the character in progress, ends any break and leaves the enable state unchanged.
- R10: Disable (code 2) empties the queue, abandons the character in progress, ends any break and returns the line to mark. Enable is code 1. Code 0 and codes 6 and 7 have no effect. Begin-break is ignored while the transmitter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud tick, one clock wide, 16 per bit |
| wr_i | input | 1 | Host write strobe |
| wr_data_i | input | DATA_W | Byte to send |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command selector |
| len_sel_i | input | 2 | Data bits minus five |
| par_mode_i | input | 2 | Parity mode |
| two_stop_i | input | 1 | Two stop bits when 1 |
| txd_o | output | 1 | Serial line |
| tx_rdy_o | output | 1 | Queue empty and transmitter enabled |
| tx_emt_o | output | 1 | Transmitter fully drained |

## Verification
The properties assume that tick_i is a synchronous pulse sampled only at clock edges. They also assume that the write strobe and a command are not raised in the same cycle, and the stimulus keeps them at least one cycle apart. The configuration inputs change only while the line is idle, so each character's framing is the one that was sampled when the byte was loaded. The bench sweeps every combination of length, parity and stop bits with two back-to-back characters. It then covers break, overflow, disable and reset-transmitter sequences, each applied partway through a character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ENABLE  = 3'd1,
    CMD_DISABLE = 3'd2,
    CMD_RESET   = 3'd3,
    CMD_BRK_ON  = 3'd4,
    CMD_BRK_OFF = 3'd5
  } tx_cmd_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_MARK = 2'd3
  } par_mode_e;

  localparam int unsigned TICKS_PER_BIT = 16;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R4
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
  // R4
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_mode_i,
  input  logic              two_stop_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              line_o
);
  localparam int unsigned FRAME_W  = DATA_W + 4;
  localparam int          MIN_BITS = int'(DATA_W) - 3;
  localparam int unsigned IDX_W    = $clog2(FRAME_W + 1);
  localparam int unsigned TICK_W   = $clog2(TICKS_PER_BIT);

  logic               busy_q;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [IDX_W-1:0]   idx_q, last_q, last_d;
  logic [TICK_W-1:0]  tcnt_q;
  logic               bit_end;

  // frame image: start, data LSB first, parity, stops (unused tail stays 1)
  always_comb begin
    int  n_data;
    int  n_bits;
    logic par_en;
    logic ones;
    n_data  = MIN_BITS + int'(len_sel_i);
    par_en  = (par_mode_i != PAR_NONE);
    ones    = 1'b0;
    frame_d = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (i < n_data) begin
        frame_d[i+1] = data_i[i];
        ones = ones ^ data_i[i];
      end
    end
    for (int i = 1; i < int'(FRAME_W); i++) begin
      if (par_en && i == n_data + 1) begin
        case (par_mode_i)
          PAR_EVEN: frame_d[i] = ones;
          PAR_ODD:  frame_d[i] = ~ones;
          default:  frame_d[i] = 1'b1;
        endcase
      end
    end
    n_bits = 1 + n_data + (par_en ? 1 : 0) + (two_stop_i ? 2 : 1);
    last_d = IDX_W'(n_bits - 1);
  end

  assign bit_end = busy_q && tick_i && (tcnt_q == TICK_W'(TICKS_PER_BIT - 1));
  assign done_o  = bit_end && (idx_q == last_q);
  assign busy_o  = busy_q;
  assign line_o  = frame_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      idx_q   <= '0;
      last_q  <= '0;
      tcnt_q  <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
    end else if (!busy_q) begin
      if (load_i) begin
        busy_q  <= 1'b1;
        frame_q <= frame_d;
        last_q  <= last_d;
        idx_q   <= '0;
        tcnt_q  <= '0;
      end
    end else if (tick_i) begin
      tcnt_q <= tcnt_q + TICK_W'(1);
      if (done_o) begin
        busy_q  <= 1'b0;
        frame_q <= '1;
      end else if (bit_end) begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        idx_q   <= idx_q + IDX_W'(1);
      end
    end
  end

  // R2
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_q && !abort_i) |=> (!line_o && busy_o));
  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !abort_i) |=> $stable(line_o));
  // R8
  abort_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (line_o && !busy_o));
  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !abort_i) |=> (line_o && !busy_o));
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       cmd_vld_i,
  input  logic [2:0] cmd_i,
  input  logic       fifo_empty_i,
  input  logic       fifo_full_i,
  input  logic       sh_busy_i,
  input  logic       sh_done_i,
  output logic       en_o,
  output logic       brk_o,
  output logic       flush_o,
  output logic       abort_o,
  output logic       push_o,
  output logic       load_o,
  output logic       rdy_o,
  output logic       emt_o
);
  logic en_q, brk_q, emt_q;
  logic c_en, c_dis, c_rst, c_bon, c_boff;

  assign c_en   = cmd_vld_i && (cmd_i == CMD_ENABLE);
  assign c_dis  = cmd_vld_i && (cmd_i == CMD_DISABLE);
  assign c_rst  = cmd_vld_i && (cmd_i == CMD_RESET);
  assign c_bon  = cmd_vld_i && (cmd_i == CMD_BRK_ON) && en_q;
  assign c_boff = cmd_vld_i && (cmd_i == CMD_BRK_OFF);

  assign flush_o = c_dis || c_rst;
  assign abort_o = c_dis || c_rst || c_bon;
  assign push_o  = wr_i && en_q && !fifo_full_i && !flush_o;
  assign load_o  = en_q && !brk_q && !fifo_empty_i && !sh_busy_i && !abort_o;
  assign rdy_o   = en_q && fifo_empty_i;
  assign en_o    = en_q;
  assign brk_o   = brk_q;
  assign emt_o   = emt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
      emt_q <= 1'b0;
    end else begin
      if (c_en)       en_q <= 1'b1;
      else if (c_dis) en_q <= 1'b0;

      if (c_dis || c_rst || c_boff) brk_q <= 1'b0;
      else if (c_bon)               brk_q <= 1'b1;

      if (c_dis || c_rst || push_o)                emt_q <= 1'b0;
      else if (sh_done_i && fifo_empty_i && !c_bon) emt_q <= 1'b1;
    end
  end

  // R10
  dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_i == CMD_DISABLE) |=> (!rdy_o && !emt_o && !brk_o && !en_o));
  // R9
  rst_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_i == CMD_RESET) |=> (!brk_o && !emt_o && (en_o == $past(en_q))));
  // R5
  en_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_i == CMD_ENABLE && fifo_empty_i && !wr_i) |=> rdy_o);
  // R6
  emt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !emt_o);
  // R10
  bon_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_i == CMD_BRK_ON && !en_q && !brk_q) |=> !brk_o);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cmd_vld_i,
  input  logic [2:0]        cmd_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_mode_i,
  input  logic              two_stop_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_emt_o
);
  logic              en, brk, flush, abort, push, load;
  logic              f_empty, f_full;
  logic [DATA_W-1:0] f_data;
  logic              sh_busy, sh_done, sh_line;

  uart_tx_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .cmd_vld_i    (cmd_vld_i),
    .cmd_i        (cmd_i),
    .fifo_empty_i (f_empty),
    .fifo_full_i  (f_full),
    .sh_busy_i    (sh_busy),
    .sh_done_i    (sh_done),
    .en_o         (en),
    .brk_o        (brk),
    .flush_o      (flush),
    .abort_o      (abort),
    .push_o       (push),
    .load_o       (load),
    .rdy_o        (tx_rdy_o),
    .emt_o        (tx_emt_o)
  );

  uart_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .data_i  (wr_data_i),
    .pop_i   (load),
    .data_o  (f_data),
    .empty_o (f_empty),
    .full_o  (f_full)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .data_i     (f_data),
    .len_sel_i  (len_sel_i),
    .par_mode_i (par_mode_i),
    .two_stop_i (two_stop_i),
    .abort_i    (abort),
    .busy_o     (sh_busy),
    .done_o     (sh_done),
    .line_o     (sh_line)
  );

  assign txd_o = brk ? 1'b0 : sh_line;

  // R8
  brk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_i == CMD_BRK_ON && en) |=> !txd_o);
  // R7
  wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !en && !cmd_vld_i && f_empty) |=> f_empty);
  // R6
  emt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_done && f_empty && !wr_i && !cmd_vld_i) |=> (tx_emt_o && txd_o));
  // R5
  rdy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !wr_i && !cmd_vld_i && !tx_rdy_o) |=> ($rose(tx_rdy_o) == f_empty));
endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       cmd_vld = 1'b0;
  logic [2:0] cmd = '0;
  logic [1:0] len_sel = 2'd3;
  logic [1:0] par_mode = 2'd0;
  logic       two_stop = 1'b0;
  logic       txd, rdy, emt;
  int checks = 0;
  int failures = 0;
  int div = 0;

  always #2 clk = ~clk;

  uart_tx_core #(.DATA_W(8), .DEPTH(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .cmd_vld_i(cmd_vld), .cmd_i(cmd), .len_sel_i(len_sel), .par_mode_i(par_mode),
    .two_stop_i(two_stop), .txd_o(txd), .tx_rdy_o(rdy), .tx_emt_o(emt)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      div  <= 0;
      tick <= 1'b0;
    end else begin
      div  <= (div == 3) ? 0 : div + 1;
      tick <= (div == 3);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] c);
    @(negedge clk); cmd_vld = 1'b1; cmd = c;
    @(negedge clk); cmd_vld = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  task automatic wait_fall();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (txd && guard < 4000);
  endtask

  // count cycles where the line differs from lvl over n clocks
  task automatic hold_line(input int n, input logic lvl, input string req);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (txd !== lvl) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input int len,
                                            input int par, input int two, output int nb);
    logic [11:0] f;
    int nd, ones;
    nd = 5 + len;
    ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      f[i+1] = d[i];
      ones += int'(d[i]);
    end
    nb = 1 + nd;
    if (par != 0) begin
      f[nb] = (par == 1) ? logic'(ones % 2) : (par == 2) ? logic'(1 - ones % 2) : 1'b1;
      nb++;
    end
    nb += (two != 0) ? 2 : 1;
    return f;
  endfunction

  // R2 R3: sample each bit at its middle tick
  task automatic recv_check(input logic [7:0] d, input int len, input int par,
                            input int two, input string req);
    int nb;
    logic [11:0] f;
    f = exp_frame(d, len, par, two, nb);
    wait_fall();
    check(txd == 1'b0, req, int'(txd), 0);
    for (int k = 0; k < nb; k++) begin
      wait_ticks((k == 0) ? 8 : 16);
      @(negedge clk);
      check(txd == f[k], req, int'(txd), int'(f[k]));
    end
    wait_ticks(8);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1
    check(txd == 1'b1, "R1", int'(txd), 1);
    check(rdy == 1'b0, "R1", int'(rdy), 0);
    check(emt == 1'b0, "R1", int'(emt), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: write while disabled is dropped
    do_write(8'hA5);
    hold_line(40, 1'b1, "R7");
    do_cmd(3'd1);
    check(rdy == 1'b1, "R5", int'(rdy), 1);
    check(emt == 1'b0, "R6", int'(emt), 0);
    hold_line(200, 1'b1, "R7");

    // R2 R3: full configuration sweep, two back-to-back characters
    for (int len = 0; len < 4; len++) begin
      for (int par = 0; par < 4; par++) begin
        for (int two = 0; two < 2; two++) begin
          logic [7:0] d1, d2;
          int idx;
          idx = len * 8 + par * 2 + two;
          d1 = 8'((idx * 53 + 29) & 255);
          d2 = ~d1;
          @(negedge clk);
          len_sel = 2'(len); par_mode = 2'(par); two_stop = two[0];
          do_write(d1);
          fork
            begin
              recv_check(d1, len, par, two, "R2");
              check(emt == 1'b0, "R6", int'(emt), 0);
              recv_check(d2, len, par, two, "R3");
            end
            begin
              repeat (2) @(negedge clk);
              do_write(d2);
              check(rdy == 1'b0, "R5", int'(rdy), 0);
              check(emt == 1'b0, "R6", int'(emt), 0);
            end
          join
          check(emt == 1'b1, "R6", int'(emt), 1);
          check(rdy == 1'b1, "R5", int'(rdy), 1);
        end
      end
    end

    // R4 R8: queue held during break, overflow dropped, order kept
    @(negedge clk);
    len_sel = 2'd3; par_mode = 2'd0; two_stop = 1'b0;
    do_cmd(3'd4);
    check(txd == 1'b0, "R8", int'(txd), 0);
    for (int k = 0; k < 6; k++) do_write(8'(8'h10 + k));
    check(rdy == 1'b0, "R5", int'(rdy), 0);
    check(emt == 1'b0, "R6", int'(emt), 0);
    hold_line(200, 1'b0, "R8");
    do_cmd(3'd5);
    for (int k = 0; k < 4; k++) recv_check(8'(8'h10 + k), 3, 0, 0, "R4");
    check(emt == 1'b1, "R6", int'(emt), 1);
    hold_line(300, 1'b1, "R4");

    // R8: break abandons the character in progress
    do_write(8'h3C);
    wait_fall();
    wait_ticks(40);
    do_cmd(3'd4);
    check(txd == 1'b0, "R8", int'(txd), 0);
    hold_line(120, 1'b0, "R8");
    do_cmd(3'd5);
    check(txd == 1'b1, "R8", int'(txd), 1);
    hold_line(300, 1'b1, "R8");
    check(emt == 1'b0, "R6", int'(emt), 0);
    check(rdy == 1'b1, "R5", int'(rdy), 1);

    // R9: reset-transmitter mid character keeps enable
    do_write(8'h00);
    do_write(8'h00);
    wait_ticks(30);
    do_cmd(3'd3);
    check(txd == 1'b1, "R9", int'(txd), 1);
    check(rdy == 1'b1, "R9", int'(rdy), 1);
    check(emt == 1'b0, "R9", int'(emt), 0);
    hold_line(800, 1'b1, "R9");
    do_write(8'h5A);
    recv_check(8'h5A, 3, 0, 0, "R9");
    check(emt == 1'b1, "R6", int'(emt), 1);

    // R10: disable flushes and aborts
    do_write(8'h00);
    do_write(8'h00);
    wait_ticks(30);
    do_cmd(3'd2);
    check(txd == 1'b1, "R10", int'(txd), 1);
    check(rdy == 1'b0, "R10", int'(rdy), 0);
    check(emt == 1'b0, "R6", int'(emt), 0);
    hold_line(200, 1'b1, "R10");
    do_cmd(3'd1);
    check(rdy == 1'b1, "R5", int'(rdy), 1);
    hold_line(800, 1'b1, "R10");

    // R10: break ignored while disabled, unused codes inert
    do_cmd(3'd2);
    do_cmd(3'd4);
    check(txd == 1'b1, "R10", int'(txd), 1);
    do_cmd(3'd1);
    hold_line(100, 1'b1, "R10");
    do_cmd(3'd7);
    do_cmd(3'd6);
    do_cmd(3'd0);
    check(rdy == 1'b1, "R10", int'(rdy), 1);
    do_write(8'hC3);
    recv_check(8'hC3, 3, 0, 0, "R10");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule